// File: doc/BRIEF.md
# Plug Control Register Lock Handler

This block holds the connection-control registers that an audio/video node exposes for its isochronous plugs. There are two master registers, one for the output side and one for the input side. Each output plug and each input plug has a control register of its own. The registers sit in a fixed window of the node's address space. They are reached through a simplified transaction port that carries an offset, a transaction kind, an extended code, a length, a compare argument and a data value.

Quadlet reads and block reads are served directly. The only way to change a register is a 32-bit compare-and-swap lock. A lock is stored only when the compare matches and the new value obeys the modification rules:
- A connected output plug keeps its channel and speed fields.
- An input plug with point-to-point connections keeps its channel.
- An extended speed may only be set together with the top speed code.
- The first broadcast connection of an otherwise unconnected output plug gets its channel assigned by hardware.

The online bit of each plug and the plug-count fields of the masters are driven by the device. Per-plug transmit and receive enables are derived from the stored values.

Top module: `plug_regs`

## Requirements
- R1: The window has bits [47:8] = 0xFFFF_F000_09. The output master is at low offset 0x900, output plug n at 0x904+4n, the input master at 0x980 and input plug n at 0x984+4n. A quadlet read of an implemented register answers code 0 (complete) with its value one cycle after acceptance. After reset every stored bit is zero. Reads show the device's online input in plug bit [31] and the plug count (N_OUT or N_IN) in master bits [4:0].
- R2: These requests are answered with code 7 (address error) and data 0: a quadlet read that is unaligned, outside the window or at an unimplemented slot, and a lock that is otherwise valid but aimed at an unimplemented slot.
- R3: Quadlet writes (kind 2) and block writes (kind 3) never change a register. They answer code 6 (type error) inside the window and code 7 outside it.
- R4: A lock (kind 4) inside the window answers code 6 and stores nothing if any of these holds: the offset is not quadlet aligned, the extended code is not 2, or the length is not 4.
- R5: A lock whose argument differs from the current value answers code 0, returns the current value and stores nothing.
- R6: A lock whose argument matches and whose new value is legal stores the new value and returns the old value with code 0. The online bit and the master plug-count field stay read-only.
- R7: The output plug layout is: [31] online, [30] broadcast, [29:24] point-to-point count, [23:22] xspd, [21:16] channel, [15:14] spd, [13:10] overhead, [9:0] payload. While the plug is connected (broadcast set or count nonzero), a lock that changes channel, spd or xspd answers code 4 (conflict), returns the current value and stores nothing.
- R8: The input plug uses the same online, broadcast, count and channel positions. While its point-to-point count is nonzero, a lock that changes the channel answers code 4 and stores nothing.
- R9: In either master, the layout is [31:30] spd and [23:22] xspd, and the output master also holds [29:24] broadcast base. A lock that sets xspd nonzero with spd below 3 answers code 4 and stores nothing. The same applies to an output plug.
- R10: When an output-plug lock raises broadcast from 0 to 1, the point-to-point count must be zero before and after. The stored channel is then 63 if the broadcast base is 63, and (base+n) mod 63 otherwise.
- R11: tx_en[n] is high only if all of these hold: output plug n is online, it is connected, its spd is not above the master spd, and it does not have spd 3 with xspd above the master xspd. rx_en[n] is high only if input plug n is online and connected.
- R12: A block read (kind 1) completes only if it is aligned, its length is a nonzero multiple of 4 and its range lies inside the window. It then gives one beat per cycle, with zeros for unimplemented slots and rsp_last on the final beat, and req_ready stays low between the beats. Any other block read gives a single code-7 beat with rsp_last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high |
| req_kind | input | 3 | 0 qread, 1 bread, 2 qwrite, 3 bwrite, 4 lock |
| req_offset | input | 48 | Byte offset in node space |
| req_ext | input | 16 | Extended transaction code |
| req_len | input | 16 | Data length in bytes |
| req_arg | input | 32 | Lock compare value |
| req_data | input | 32 | Lock new value |
| out_online | input | N_OUT | Device online status per output plug |
| in_online | input | N_IN | Device online status per input plug |
| rsp_valid | output | 1 | Response beat present |
| rsp_code | output | 4 | Response code |
| rsp_data | output | 32 | Read data or old value |
| rsp_last | output | 1 | Final beat of the response |
| tx_en | output | N_OUT | Output plug may transmit |
| rx_en | output | N_IN | Input plug may receive |

## Verification
A quadlet read is swept over all 64 slots of the window. This separates implemented registers, unimplemented ones and the fields driven by the device. Locks are tried in several forms:
- malformed, which must give a type error;
- with a stale argument, which must be ignored;
- legal;
- rule-breaking on a connected plug, which must conflict.

A sweep over several broadcast bases and every output plug checks the modulo-63 channel assignment, including the base-63 and wrap-around cases. A block read that straddles the two plug groups shows the zero fill and the beat timing. Master speed changes toggle the transmit enable of a connected plug.

// File: rtl/plug_regs_pkg.sv
package plug_regs_pkg;

    localparam logic [39:0] WINDOW_HI = 40'hFFFF_F000_09;
    localparam logic [15:0] EXT_CMP_SWAP = 16'd2;

    typedef enum logic [2:0] {
        REQ_QREAD  = 3'd0,
        REQ_BREAD  = 3'd1,
        REQ_QWRITE = 3'd2,
        REQ_BWRITE = 3'd3,
        REQ_LOCK   = 3'd4
    } req_kind_e;

    localparam logic [3:0] RSP_COMPLETE = 4'h0;
    localparam logic [3:0] RSP_CONFLICT = 4'h4;
    localparam logic [3:0] RSP_TYPE_ERR = 4'h6;
    localparam logic [3:0] RSP_ADDR_ERR = 4'h7;

    typedef enum logic [1:0] {
        SLOT_OMASTER,
        SLOT_OPLUG,
        SLOT_IMASTER,
        SLOT_IPLUG
    } slot_kind_e;

    typedef struct packed {
        logic       online;
        logic       bcast;
        logic [5:0] p2p;
        logic [1:0] xspd;
        logic [5:0] chan;
        logic [1:0] spd;
        logic [3:0] ovh;
        logic [9:0] payload;
    } plug_word_t;

    typedef struct packed {
        logic [1:0]  spd;
        logic [5:0]  base;
        logic [1:0]  xspd;
        logic [16:0] spare;
        logic [4:0]  count;
    } master_word_t;

    function automatic logic is_connected(plug_word_t w);
        return w.bcast || (w.p2p != 6'd0);
    endfunction

    function automatic logic [5:0] bcast_channel(logic [5:0] base, logic [4:0] n);
        logic [6:0] sum;
        if (base == 6'd63) return 6'd63;
        sum = {1'b0, base} + {2'b00, n};
        if (sum >= 7'd63) sum = sum - 7'd63;
        return sum[5:0];
    endfunction

endpackage

// File: rtl/plug_req_decode.sv
module plug_req_decode
    import plug_regs_pkg::*;
#(
    parameter int N_OUT = 3,
    parameter int N_IN  = 2
) (
    input  logic [2:0]  req_kind,
    input  logic [47:0] req_offset,
    input  logic [15:0] req_ext,
    input  logic [15:0] req_len,
    output logic        err,
    output logic [3:0]  err_code,
    output logic        is_lock,
    output logic        is_bread,
    output logic [5:0]  idx,
    output logic [6:0]  nq
);
    logic        in_space;
    logic        aligned;
    logic        impl;
    logic [4:0]  pos;
    logic [16:0] span;

    assign in_space = (req_offset[47:8] == WINDOW_HI);
    assign aligned  = (req_offset[1:0] == 2'b00);
    assign idx      = req_offset[7:2];
    assign pos      = idx[4:0];
    assign impl     = idx[5] ? (int'(pos) <= N_IN) : (int'(pos) <= N_OUT);
    assign span     = {11'd0, idx} + {3'd0, req_len[15:2]};
    assign nq       = req_len[8:2];

    always_comb begin
        err      = 1'b0;
        err_code = RSP_COMPLETE;
        is_lock  = 1'b0;
        is_bread = 1'b0;
        case (req_kind_e'(req_kind))
            REQ_QREAD: begin
                if (!in_space || !aligned || !impl) begin
                    err = 1'b1; err_code = RSP_ADDR_ERR;
                end
            end
            REQ_BREAD: begin
                is_bread = 1'b1;
                if (!in_space || !aligned || req_len[1:0] != 2'b00 ||
                    req_len == 16'd0 || span > 17'd64) begin
                    err = 1'b1; err_code = RSP_ADDR_ERR;
                end
            end
            REQ_QWRITE, REQ_BWRITE: begin
                err = 1'b1;
                err_code = in_space ? RSP_TYPE_ERR : RSP_ADDR_ERR;
            end
            REQ_LOCK: begin
                is_lock = 1'b1;
                if (!in_space) begin
                    err = 1'b1; err_code = RSP_ADDR_ERR;
                end else if (!aligned || req_ext != EXT_CMP_SWAP || req_len != 16'd4) begin
                    err = 1'b1; err_code = RSP_TYPE_ERR;
                end else if (!impl) begin
                    err = 1'b1; err_code = RSP_ADDR_ERR;
                end
            end
            default: begin
                err = 1'b1; err_code = RSP_TYPE_ERR;
            end
        endcase
    end
endmodule

// File: rtl/plug_lock_rules.sv
module plug_lock_rules
    import plug_regs_pkg::*;
(
    input  slot_kind_e  kind,
    input  logic [4:0]  plug_n,
    input  logic [31:0] cur,
    input  logic [31:0] nxt,
    input  logic [5:0]  obase,
    output logic        legal,
    output logic [31:0] store
);
    plug_word_t   pc;
    plug_word_t   pn;
    plug_word_t   ps;
    master_word_t mn;

    assign pc = plug_word_t'(cur);
    assign pn = plug_word_t'(nxt);
    assign mn = master_word_t'(nxt);

    always_comb begin
        legal = 1'b1;
        ps    = pn;
        case (kind)
            SLOT_OMASTER, SLOT_IMASTER: begin
                if (mn.spd != 2'd3 && mn.xspd != 2'd0) legal = 1'b0;
            end
            SLOT_OPLUG: begin
                if (pn.spd != 2'd3 && pn.xspd != 2'd0) legal = 1'b0;
                if (is_connected(pc) &&
                    (pn.chan != pc.chan || pn.spd != pc.spd || pn.xspd != pc.xspd))
                    legal = 1'b0;
                if (!pc.bcast && pn.bcast && pc.p2p == 6'd0 && pn.p2p == 6'd0)
                    ps.chan = bcast_channel(obase, plug_n);
            end
            SLOT_IPLUG: begin
                if (pc.p2p != 6'd0 && pn.chan != pc.chan) legal = 1'b0;
            end
            default: legal = 1'b0;
        endcase
        store = ps;
    end
endmodule

// File: rtl/plug_regs.sv
module plug_regs
    import plug_regs_pkg::*;
#(
    parameter int N_OUT = 3,
    parameter int N_IN  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_kind,
    input  logic [47:0]       req_offset,
    input  logic [15:0]       req_ext,
    input  logic [15:0]       req_len,
    input  logic [31:0]       req_arg,
    input  logic [31:0]       req_data,
    input  logic [N_OUT-1:0]  out_online,
    input  logic [N_IN-1:0]   in_online,
    output logic              rsp_valid,
    output logic [3:0]        rsp_code,
    output logic [31:0]       rsp_data,
    output logic              rsp_last,
    output logic [N_OUT-1:0]  tx_en,
    output logic [N_IN-1:0]   rx_en
);
    localparam int SLOTS = 64;
    localparam int IBASE = SLOTS / 2;

    logic [31:0] o_mst, i_mst;
    logic [31:0] o_pcr [N_OUT];
    logic [31:0] i_pcr [N_IN];
    logic [31:0] view  [SLOTS];

    logic        busy;
    logic [5:0]  bidx;
    logic [6:0]  brem;

    logic        d_err, d_lock, d_bread;
    logic [3:0]  d_code;
    logic [5:0]  d_idx;
    logic [6:0]  d_nq;
    logic [4:0]  d_pos;
    logic [4:0]  plug_n;
    slot_kind_e  slot;
    logic [31:0] cur;
    logic        legal;
    logic [31:0] store;
    logic        acc;
    logic        we;
    master_word_t om;

    assign req_ready = !busy;
    assign acc       = req_valid && req_ready;
    assign om        = master_word_t'(o_mst);

    plug_req_decode #(.N_OUT(N_OUT), .N_IN(N_IN)) u_dec (
        .req_kind(req_kind), .req_offset(req_offset), .req_ext(req_ext),
        .req_len(req_len), .err(d_err), .err_code(d_code), .is_lock(d_lock),
        .is_bread(d_bread), .idx(d_idx), .nq(d_nq)
    );

    always_comb begin
        for (int k = 0; k < SLOTS; k++) view[k] = 32'd0;
        view[0] = {o_mst[31:5], 5'(N_OUT)};
        for (int n = 0; n < N_OUT; n++) view[1 + n] = {out_online[n], o_pcr[n][30:0]};
        view[IBASE] = {i_mst[31:5], 5'(N_IN)};
        for (int n = 0; n < N_IN; n++) view[IBASE + 1 + n] = {in_online[n], i_pcr[n][30:0]};
    end

    assign d_pos  = d_idx[4:0];
    assign plug_n = d_pos - 5'd1;
    assign cur    = view[d_idx];

    always_comb begin
        if (d_idx[5]) slot = (d_pos == 5'd0) ? SLOT_IMASTER : SLOT_IPLUG;
        else          slot = (d_pos == 5'd0) ? SLOT_OMASTER : SLOT_OPLUG;
    end

    plug_lock_rules u_rules (
        .kind(slot), .plug_n(plug_n), .cur(cur), .nxt(req_data),
        .obase(om.base), .legal(legal), .store(store)
    );

    assign we = acc && d_lock && !d_err && (cur == req_arg) && legal;

    always_ff @(posedge clk) begin
        if (rst) begin
            o_mst <= '0;
            i_mst <= '0;
            for (int n = 0; n < N_OUT; n++) o_pcr[n] <= '0;
            for (int n = 0; n < N_IN; n++)  i_pcr[n] <= '0;
        end else if (we) begin
            if (slot == SLOT_OMASTER) o_mst <= store;
            if (slot == SLOT_IMASTER) i_mst <= store;
            for (int n = 0; n < N_OUT; n++)
                if (slot == SLOT_OPLUG && int'(plug_n) == n) o_pcr[n] <= store;
            for (int n = 0; n < N_IN; n++)
                if (slot == SLOT_IPLUG && int'(plug_n) == n) i_pcr[n] <= store;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_code  <= RSP_COMPLETE;
            rsp_data  <= '0;
            rsp_last  <= 1'b0;
            busy      <= 1'b0;
            bidx      <= '0;
            brem      <= '0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_last  <= 1'b0;
            if (busy) begin
                rsp_valid <= 1'b1;
                rsp_code  <= RSP_COMPLETE;
                rsp_data  <= view[bidx];
                rsp_last  <= (brem == 7'd1);
                busy      <= (brem != 7'd1);
                brem      <= brem - 7'd1;
                bidx      <= bidx + 6'd1;
            end else if (acc) begin
                rsp_valid <= 1'b1;
                rsp_last  <= 1'b1;
                if (d_err) begin
                    rsp_code <= d_code;
                    rsp_data <= '0;
                end else if (d_lock) begin
                    rsp_data <= cur;
                    rsp_code <= (cur == req_arg && !legal) ? RSP_CONFLICT : RSP_COMPLETE;
                end else begin
                    rsp_data <= cur;
                    rsp_code <= RSP_COMPLETE;
                    if (d_bread && d_nq > 7'd1) begin
                        rsp_last <= 1'b0;
                        busy     <= 1'b1;
                        brem     <= d_nq - 7'd1;
                        bidx     <= d_idx + 6'd1;
                    end
                end
            end
        end
    end

    for (genvar g = 0; g < N_OUT; g++) begin : g_tx
        plug_word_t w;
        assign w = plug_word_t'(view[1 + g]);
        assign tx_en[g] = w.online && is_connected(w) && (w.spd <= om.spd) &&
                          !(w.spd == 2'd3 && w.xspd > om.xspd);
    end

    for (genvar g = 0; g < N_IN; g++) begin : g_rx
        plug_word_t w;
        assign w = plug_word_t'(view[IBASE + 1 + g]);
        assign rx_en[g] = w.online && is_connected(w);
    end
endmodule

// File: rtl/plug_regs_chk.sv
module plug_regs_chk
    import plug_regs_pkg::*;
#(
    parameter int N_OUT = 3,
    parameter int N_IN  = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic [2:0]       req_kind,
    input logic             rsp_valid,
    input logic [3:0]       rsp_code,
    input logic             rsp_last,
    input logic [N_OUT-1:0] out_online,
    input logic [N_IN-1:0]  in_online,
    input logic [N_OUT-1:0] tx_en,
    input logic [N_IN-1:0]  rx_en
);
    assert_rsp_next_R1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> rsp_valid);

    assert_write_refused_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && (req_kind == 3'd2 || req_kind == 3'd3)) |=>
        (rsp_code == RSP_TYPE_ERR || rsp_code == RSP_ADDR_ERR));

    assert_conflict_from_lock_R7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_code == RSP_CONFLICT) |->
        $past(req_valid && req_ready && req_kind == 3'd4));

    assert_tx_online_R11: assert property (@(posedge clk) disable iff (rst)
        (tx_en & ~out_online) == '0);

    assert_rx_online_R11: assert property (@(posedge clk) disable iff (rst)
        (rx_en & ~in_online) == '0);

    assert_stream_busy_R12: assert property (@(posedge clk) disable iff (rst)
        !req_ready |-> (rsp_valid && !rsp_last));

    assert_last_valid_R12: assert property (@(posedge clk) disable iff (rst)
        rsp_last |-> rsp_valid);
endmodule

bind plug_regs plug_regs_chk #(.N_OUT(N_OUT), .N_IN(N_IN)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
    .rsp_last(rsp_last), .out_online(out_online), .in_online(in_online),
    .tx_en(tx_en), .rx_en(rx_en)
);

// File: tb/tb_plug_regs.sv
module tb_plug_regs;
    localparam int N_OUT = 3;
    localparam int N_IN  = 2;
    localparam logic [47:0] BASE = 48'hFFFF_F000_0900;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [2:0]        req_kind = 3'd0;
    logic [47:0]       req_offset = '0;
    logic [15:0]       req_ext = 16'd0;
    logic [15:0]       req_len = 16'd0;
    logic [31:0]       req_arg = '0;
    logic [31:0]       req_data = '0;
    logic [N_OUT-1:0]  out_online = '1;
    logic [N_IN-1:0]   in_online = '1;
    logic              rsp_valid;
    logic [3:0]        rsp_code;
    logic [31:0]       rsp_data;
    logic              rsp_last;
    logic [N_OUT-1:0]  tx_en;
    logic [N_IN-1:0]   rx_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    plug_regs #(.N_OUT(N_OUT), .N_IN(N_IN)) dut (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xact(input logic [2:0] kind, input logic [47:0] off, input logic [15:0] ext,
                        input logic [15:0] len, input logic [31:0] arg, input logic [31:0] dat,
                        output logic [3:0] code, output logic [31:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_offset = off;
        req_ext = ext; req_len = len; req_arg = arg; req_data = dat;
        @(negedge clk);
        req_valid = 1'b0;
        code = rsp_valid ? rsp_code : 4'hF;
        d = rsp_data;
    endtask

    task automatic qread(input logic [47:0] off, output logic [3:0] code, output logic [31:0] d);
        xact(3'd0, off, 16'd0, 16'd4, 32'd0, 32'd0, code, d);
    endtask

    task automatic lock(input logic [47:0] off, input logic [31:0] arg, input logic [31:0] dat,
                        output logic [3:0] code, output logic [31:0] d);
        xact(3'd4, off, 16'd2, 16'd4, arg, dat, code, d);
    endtask

    function automatic logic [47:0] oplug(input int n); return BASE + 48'(4 + 4 * n); endfunction
    function automatic logic [47:0] iplug(input int n); return BASE + 48'(132 + 4 * n); endfunction

    function automatic logic [31:0] expect_view(input int k);
        if (k == 0) return 32'd3;
        if (k >= 1 && k <= N_OUT) return 32'h8000_0000;
        if (k == 32) return 32'd2;
        if (k >= 33 && k <= 32 + N_IN) return 32'h8000_0000;
        return 32'd0;
    endfunction

    function automatic logic [31:0] set_chan(input logic [31:0] w, input int ch);
        return (w & ~32'h003F_0000) | (32'(ch) << 16);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [3:0]  c;
        logic [31:0] d, v, m, i_mst_v, i0_v, i1_v;
        logic [31:0] beats [0:69];
        int nb, rdy_hi;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 / R2: sweep the whole window after reset
        for (int k = 0; k < 64; k++) begin
            qread(BASE + 48'(4 * k), c, d);
            if (expect_view(k) != 0 || k == 0 || k == 32 || (k >= 1 && k <= N_OUT) ||
                (k >= 33 && k <= 32 + N_IN)) begin
                check($sformatf("R1 code slot %0d", k), {28'd0, c}, 32'd0);
                check($sformatf("R1 data slot %0d", k), d, expect_view(k));
            end else begin
                check($sformatf("R2 code slot %0d", k), {28'd0, c}, 32'd7);
                check($sformatf("R2 data slot %0d", k), d, 32'd0);
            end
        end
        qread(BASE + 48'd2, c, d);          check("R2 unaligned read", {28'd0, c}, 32'd7);
        qread(48'hFFFF_F000_0A00, c, d);    check("R2 outside window", {28'd0, c}, 32'd7);
        lock(oplug(N_OUT), 32'd0, 32'd1, c, d); check("R2 lock unimplemented", {28'd0, c}, 32'd7);

        // R3: writes refused
        xact(3'd2, oplug(0), 16'd0, 16'd4, 32'd0, 32'hFFFF_FFFF, c, d);
        check("R3 qwrite code", {28'd0, c}, 32'd6);
        xact(3'd3, BASE + 48'h80, 16'd0, 16'd8, 32'd0, 32'hFFFF_FFFF, c, d);
        check("R3 bwrite code", {28'd0, c}, 32'd6);
        xact(3'd2, 48'h0000_0000_0400, 16'd0, 16'd4, 32'd0, 32'd1, c, d);
        check("R3 qwrite outside", {28'd0, c}, 32'd7);
        qread(oplug(0), c, d);              check("R3 unchanged", d, 32'h8000_0000);

        // R4: malformed locks
        xact(3'd4, oplug(0), 16'd1, 16'd4, 32'h8000_0000, 32'd5, c, d);
        check("R4 ext code", {28'd0, c}, 32'd6);
        xact(3'd4, oplug(0), 16'd2, 16'd8, 32'h8000_0000, 32'd5, c, d);
        check("R4 length", {28'd0, c}, 32'd6);
        xact(3'd4, oplug(0) + 48'd1, 16'd2, 16'd4, 32'h8000_0000, 32'd5, c, d);
        check("R4 unaligned", {28'd0, c}, 32'd6);
        qread(oplug(0), c, d);              check("R4 unchanged", d, 32'h8000_0000);

        // R5: stale compare
        lock(oplug(1), 32'd0, 32'h0000_0123, c, d);
        check("R5 code", {28'd0, c}, 32'd0);
        check("R5 old", d, 32'h8000_0000);
        qread(oplug(1), c, d);              check("R5 unchanged", d, 32'h8000_0000);

        // R6: legal lock, read-only fields
        lock(oplug(1), 32'h8000_0000, 32'h0000_0123, c, d);
        check("R6 code", {28'd0, c}, 32'd0);
        check("R6 old", d, 32'h8000_0000);
        qread(oplug(1), c, d);              check("R6 stored", d, 32'h8000_0123);
        @(negedge clk); out_online[1] = 1'b0;
        qread(oplug(1), c, d);              check("R6 online driven", d, 32'h0000_0123);
        out_online[1] = 1'b1;
        lock(BASE, 32'd3, 32'h0000_001F, c, d);
        check("R6 master code", {28'd0, c}, 32'd0);
        qread(BASE, c, d);                  check("R6 count read-only", d, 32'd3);

        // R9: xspd without top speed
        lock(BASE, 32'd3, 32'h4040_0000, c, d);
        check("R9 master conflict", {28'd0, c}, 32'd4);
        check("R9 master old", d, 32'd3);
        qread(BASE, c, d);                  check("R9 master unchanged", d, 32'd3);
        lock(oplug(2), 32'h8000_0000, 32'h0080_0000, c, d);
        check("R9 plug conflict", {28'd0, c}, 32'd4);
        lock(BASE, 32'd3, 32'hCA40_0000, c, d);
        check("R9 legal master", {28'd0, c}, 32'd0);

        // R10: broadcast channel assignment sweep
        foreach (beats[i]) beats[i] = 32'd0;
        for (int b = 0; b < 4; b++) begin
            int base_v;
            base_v = (b == 0) ? 10 : (b == 1) ? 62 : (b == 2) ? 63 : 60;
            qread(BASE, c, m);
            lock(BASE, m, 32'hC040_0000 | (32'(base_v) << 24), c, d);
            check($sformatf("R10 set base %0d", base_v), {28'd0, c}, 32'd0);
            for (int n = 0; n < N_OUT; n++) begin
                int exp_ch;
                exp_ch = (base_v == 63) ? 63 : (base_v + n) % 63;
                qread(oplug(n), c, v);
                lock(oplug(n), v, v | 32'h4000_0000, c, d);
                qread(oplug(n), c, v);
                check($sformatf("R10 chan base %0d plug %0d", base_v, n), (v >> 16) & 32'h3F, 32'(exp_ch));
                lock(oplug(n), v, v & ~32'h4000_0000, c, d);
                check($sformatf("R10 release plug %0d", n), {28'd0, c}, 32'd0);
            end
        end

        // R7: connected output plug
        qread(oplug(0), c, v);
        lock(oplug(0), v, set_chan(v | 32'h0100_0000, 5), c, d);
        check("R7 connect", {28'd0, c}, 32'd0);
        qread(oplug(0), c, v);              check("R7 chan", (v >> 16) & 32'h3F, 32'd5);
        lock(oplug(0), v, set_chan(v, 6) + 32'h0100_0000, c, d);
        check("R7 chan change conflict", {28'd0, c}, 32'd4);
        check("R7 returns current", d, v);
        lock(oplug(0), v, v | 32'h0000_4000, c, d);
        check("R7 spd change conflict", {28'd0, c}, 32'd4);
        lock(oplug(0), v, v | 32'h0000_0040, c, d);
        check("R7 payload change ok", {28'd0, c}, 32'd0);
        qread(oplug(0), c, d);              check("R7 stored", d, v | 32'h0000_0040);

        // R11: transmit / receive enables
        @(negedge clk);
        check("R11 tx plug0 on", {31'd0, tx_en[0]}, 32'd1);
        check("R11 tx plug1 idle", {31'd0, tx_en[1]}, 32'd0);
        out_online[0] = 1'b0;
        @(negedge clk);
        check("R11 tx offline", {31'd0, tx_en[0]}, 32'd0);
        out_online[0] = 1'b1;
        qread(oplug(2), c, v);
        lock(oplug(2), v, v | 32'h0100_0000 | 32'h0080_0000 | 32'h0000_C000, c, d);
        check("R11 connect plug2", {28'd0, c}, 32'd0);
        @(negedge clk);
        check("R11 xspd above master", {31'd0, tx_en[2]}, 32'd0);
        qread(BASE, c, m);
        lock(BASE, m, (m & ~32'h00C0_0000) | 32'h0080_0000, c, d);
        @(negedge clk);
        check("R11 xspd equal master", {31'd0, tx_en[2]}, 32'd1);
        qread(BASE, c, m);
        lock(BASE, m, (m & 32'h3F3F_FFFF) | 32'h8000_0000, c, d);
        @(negedge clk);
        check("R11 spd above master", {31'd0, tx_en[2]}, 32'd0);
        check("R11 plug0 still on", {31'd0, tx_en[0]}, 32'd1);

        // R8: input plug channel lock
        lock(iplug(0), 32'h8000_0000, 32'h0107_0000, c, d);
        check("R8 connect", {28'd0, c}, 32'd0);
        @(negedge clk);
        check("R8 rx on", {31'd0, rx_en[0]}, 32'd1);
        check("R8 rx other off", {31'd0, rx_en[1]}, 32'd0);
        lock(iplug(0), 32'h8107_0000, 32'h0108_0000, c, d);
        check("R8 chan conflict", {28'd0, c}, 32'd4);
        lock(iplug(0), 32'h8107_0000, 32'h0008_0000, c, d);
        check("R8 chan with release conflict", {28'd0, c}, 32'd4);
        lock(iplug(0), 32'h8107_0000, 32'h0007_0000, c, d);
        check("R8 release", {28'd0, c}, 32'd0);
        @(negedge clk);
        check("R8 rx off", {31'd0, rx_en[0]}, 32'd0);
        lock(iplug(0), 32'h8007_0000, 32'h0008_0000, c, d);
        check("R8 chan free", {28'd0, c}, 32'd0);

        // R12: block reads
        qread(BASE + 48'h80, c, i_mst_v);
        qread(iplug(0), c, i0_v);
        qread(iplug(1), c, i1_v);
        @(negedge clk);
        req_valid = 1'b1; req_kind = 3'd1; req_offset = BASE + 48'h78;
        req_len = 16'd24; req_ext = 16'd0;
        @(negedge clk);
        req_valid = 1'b0;
        nb = 0; rdy_hi = 0;
        while (nb < 70) begin
            beats[nb] = rsp_data;
            nb++;
            if (rsp_last) break;
            if (req_ready) rdy_hi++;
            @(negedge clk);
        end
        check("R12 beat count", 32'(nb), 32'd6);
        check("R12 ready low", 32'(rdy_hi), 32'd0);
        check("R12 zero fill 30", beats[0], 32'd0);
        check("R12 zero fill 31", beats[1], 32'd0);
        check("R12 input master", beats[2], i_mst_v);
        check("R12 input plug0", beats[3], i0_v);
        check("R12 input plug1", beats[4], i1_v);
        check("R12 zero fill 35", beats[5], 32'd0);
        xact(3'd1, BASE + 48'hFC, 16'd0, 16'd8, 32'd0, 32'd0, c, d);
        check("R12 past window", {28'd0, c}, 32'd7);
        xact(3'd1, BASE, 16'd0, 16'd6, 32'd0, 32'd0, c, d);
        check("R12 odd length", {28'd0, c}, 32'd7);
        xact(3'd1, BASE, 16'd0, 16'd0, 32'd0, 32'd0, c, d);
        check("R12 zero length", {28'd0, c}, 32'd7);
        check("R12 single beat last", {31'd0, rsp_last}, 32'd1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule